// File: doc/BRIEF.md
# Edge-Triggered Tri-State Phase-Frequency Detector

This block compares a reference input with a feedback input, normally the divided oscillator, and steers a charge-pump style loop. Both inputs are synchronised to the system clock, and only their rising edges are used. When a reference edge comes before the matching feedback edge, the block asserts a pump-up request. When the feedback edge comes first, it asserts a pump-down request. The request ends when the lagging edge arrives, and the detector then returns to a neutral state in which its single-wire output floats. Because only edges count, the duty cycle of either input has no effect. If one input runs faster than the other, the detector spends most of its time pushing in one direction, so it responds to frequency as well as to phase.

A phase flag is high exactly while the output floats. A lock detector counts reference periods in which no pump request lasted longer than a programmable number of clocks. It reports lock once a programmable number of such periods have passed in a row.

Top module: `edge_pd`

## Requirements
- R1: Falling edges and steady levels on either input leave the pump state unchanged.
- R2: A reference rising edge seen while neutral or while pumping up sets pump-up. Pump-up stays set until a feedback rising edge is seen, and the state is then neutral.
- R3: A feedback rising edge seen while neutral or while pumping down sets pump-down. Pump-down stays set until a reference rising edge is seen, and the state is then neutral.
- R4: Rising edges on both inputs in the same clock cycle give the neutral state, with no pump request.
- R5: `pump_up` and `pump_dn` are never high at the same time.
- R6: `drive_en` equals `pump_up | pump_dn`, and `phase_flag` is its inverse. `pd_pin` is 1 during pump-up, 0 during pump-down, and high impedance when neutral.
- R7: Repeated edges on the leading input do not change the direction. With only feedback edges present, the output stays in pump-down. An extra reference edge while pumping up keeps pump-up set.
- R8: While `rst_n` is low (synchronous, active low), the detector is neutral and `locked` is 0.
- R9: `locked` rises once `lock_target` reference rising edges have been seen in a row with no pump request longer than `pulse_limit` clocks.
- R10: A pump request still active after `pulse_limit` clocks clears the run of good periods, and `locked` drops on the next clock.
- R11: An input rising edge shows on the pump outputs three clock edges after the first edge that samples the new input level: two synchroniser stages, then the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal, asynchronous |
| lock_target | input | CNT_W | Number of good reference periods in a row needed for lock |
| pulse_limit | input | WID_W | Longest pump request, in clocks, that still counts as good |
| pump_up | output | 1 | Request to raise the oscillator frequency |
| pump_dn | output | 1 | Request to lower the oscillator frequency |
| drive_en | output | 1 | High while either pump request is active |
| phase_flag | output | 1 | High while the output floats |
| pd_pin | output | 1 | Tri-state pump output: 1, 0 or z |
| locked | output | 1 | Lock indication |

## Verification
The assertions assume the inputs come in as clean levels. They also assume that `lock_target` and `pulse_limit` are held steady and change only while reset is active. The stimulus holds every input level for several clocks, so each level passes through the synchroniser before the next change. It changes the lock settings only around a reset. Same-cycle rising edges are made by switching both inputs at the same moment, between clock edges.

// File: rtl/edge_pd_pkg.sv
package edge_pd_pkg;
  typedef enum logic [1:0] {
    PD_NEUTRAL = 2'b00,
    PD_UP      = 2'b01,
    PD_DN      = 2'b10
  } pd_state_t;

  localparam int unsigned NUM_INPUTS = 2;
  localparam int unsigned IDX_REF    = 0;
  localparam int unsigned IDX_FB     = 1;
endpackage

// File: rtl/edge_pd_sync.sv
module edge_pd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/edge_pd_core.sv
module edge_pd_core
  import edge_pd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic up,
  output logic dn
);
  pd_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case ({ref_rise, fb_rise})
      2'b11: state_d = PD_NEUTRAL;
      2'b10: state_d = (state_q == PD_DN) ? PD_NEUTRAL : PD_UP;
      2'b01: state_d = (state_q == PD_UP) ? PD_NEUTRAL : PD_DN;
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PD_NEUTRAL;
    else        state_q <= state_d;
  end

  assign up = (state_q == PD_UP);
  assign dn = (state_q == PD_DN);
endmodule

// File: rtl/edge_pd_lock.sv
module edge_pd_lock #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic             pumping,
  input  logic [CNT_W-1:0] target,
  input  logic [WID_W-1:0] limit,
  output logic             locked
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [WID_W-1:0] WID_MAX = {WID_W{1'b1}};

  logic [WID_W-1:0] width_q;
  logic [CNT_W-1:0] good_q;
  logic             too_long;

  assign too_long = pumping && (width_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                               width_q <= '0;
    else if (!pumping)                        width_q <= '0;
    else if (width_q != WID_MAX)              width_q <= width_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               good_q <= '0;
    else if (too_long)                        good_q <= '0;
    else if (ref_rise && good_q != CNT_MAX)   good_q <= good_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) locked <= 1'b0;
    else        locked <= !too_long && (good_q >= target) && (good_q != '0 || target == '0);
  end
endmodule

// File: rtl/edge_pd.sv
module edge_pd
  import edge_pd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned WID_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [CNT_W-1:0] lock_target,
  input  logic [WID_W-1:0] pulse_limit,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             drive_en,
  output logic             phase_flag,
  output wire              pd_pin,
  output logic             locked
);
  logic [NUM_INPUTS-1:0] raw_in;
  logic [NUM_INPUTS-1:0] rises;
  logic                  ref_rise;
  logic                  fb_rise;

  assign raw_in[IDX_REF] = ref_in;
  assign raw_in[IDX_FB]  = fb_in;

  generate
    for (genvar c = 0; c < NUM_INPUTS; c++) begin : g_in
      edge_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in[c]),
        .rise (rises[c])
      );
    end
  endgenerate

  assign ref_rise = rises[IDX_REF];
  assign fb_rise  = rises[IDX_FB];

  edge_pd_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(ref_rise),
    .fb_rise (fb_rise),
    .up      (pump_up),
    .dn      (pump_dn)
  );

  assign drive_en   = pump_up | pump_dn;
  assign phase_flag = ~drive_en;
  assign pd_pin     = drive_en ? pump_up : 1'bz;

  edge_pd_lock #(.CNT_W(CNT_W), .WID_W(WID_W)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(ref_rise),
    .pumping (drive_en),
    .target  (lock_target),
    .limit   (pulse_limit),
    .locked  (locked)
  );
endmodule

// File: rtl/edge_pd_checker.sv
module edge_pd_checker (
  input logic clk,
  input logic rst_n,
  input logic ref_rise,
  input logic fb_rise,
  input logic pump_up,
  input logic pump_dn,
  input logic drive_en,
  input logic phase_flag,
  input logic locked
);
  assert_never_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  assert_ref_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise && !pump_dn) |=> pump_up);

  assert_fb_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise && !pump_up) |=> pump_dn);

  assert_coincident_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise) |=> (!pump_up && !pump_dn));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_rise && !fb_rise) |=> ($stable(pump_up) && $stable(pump_dn)));

  assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_flag != drive_en) && (drive_en == (pump_up || pump_dn)));

  assert_reset_R8: assert property (@(posedge clk)
    !rst_n |=> (!pump_up && !pump_dn && !locked));
endmodule

bind edge_pd edge_pd_checker u_edge_pd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_rise  (ref_rise),
  .fb_rise   (fb_rise),
  .pump_up   (pump_up),
  .pump_dn   (pump_dn),
  .drive_en  (drive_en),
  .phase_flag(phase_flag),
  .locked    (locked)
);

// File: tb/edge_pd_bench.sv
module edge_pd_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic       fb_in = 1'b0;
  logic [7:0] lock_target = 8'd200;
  logic [7:0] pulse_limit = 8'd3;
  logic       pump_up, pump_dn, drive_en, phase_flag, locked;
  wire        pd_pin;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  edge_pd u_edge_pd (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .lock_target(lock_target), .pulse_limit(pulse_limit),
    .pump_up(pump_up), .pump_dn(pump_dn), .drive_en(drive_en),
    .phase_flag(phase_flag), .pd_pin(pd_pin), .locked(locked)
  );

  // {ref, fb, expected up, expected dn}
  localparam logic [3:0] VEC [18] = '{
    4'b1010, // R2 reference leads
    4'b1100, // R2 feedback ends it
    4'b0000, // R1 falling edges
    4'b0101, // R3 feedback leads
    4'b1100, // R3 reference ends it
    4'b0000, // R1
    4'b1100, // R4 both at once
    4'b0100, // R1 reference falls
    4'b0000, // R1
    4'b1010, // R2
    4'b0010, // R1 falling reference keeps up
    4'b1010, // R7 extra reference edge
    4'b1100, // R2
    4'b0000, // R1
    4'b0101, // R3
    4'b0001, // R1
    4'b0101, // R7 feedback only
    4'b1100  // R3
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_state(input string req, input logic eu, input logic ed);
    chk(req, pump_up, eu);
    chk(req, pump_dn, ed);
    chk({req, " R6 drive_en"}, drive_en, eu | ed);
    chk({req, " R6 phase_flag"}, phase_flag, ~(eu | ed));
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  initial begin
    wait_n(3);
    chk_state("R8 reset", 1'b0, 1'b0);
    chk("R8 reset locked", locked, 1'b0);
    rst_n = 1'b1;
    wait_n(1);

    foreach (VEC[i]) begin
      ref_in = VEC[i][3];
      fb_in  = VEC[i][2];
      wait_n(5);
      chk_state($sformatf("vector %0d", i), VEC[i][1], VEC[i][0]);
    end

    // R11 latency: inputs change after negedge N0; state register updates at third posedge
    ref_in = 1'b0; fb_in = 1'b0;
    do_reset();
    ref_in = 1'b1;
    wait_n(2);
    chk("R11 not yet", pump_up, 1'b0);
    wait_n(1);
    chk("R11 up after three edges", pump_up, 1'b1);

    // R8 reset while pumping up
    rst_n = 1'b0;
    wait_n(1);
    chk_state("R8 reset mid pulse", 1'b0, 1'b0);
    ref_in = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);

    // Lock detection
    lock_target = 8'd4;
    pulse_limit = 8'd3;
    do_reset();
    for (int p = 0; p < 3; p++) begin
      ref_in = 1'b1; fb_in = 1'b1; wait_n(4);
      ref_in = 1'b0; fb_in = 1'b0; wait_n(4);
    end
    chk("R9 three periods", locked, 1'b0);
    ref_in = 1'b1; fb_in = 1'b1; wait_n(4);
    chk("R9 fourth period", locked, 1'b1);
    ref_in = 1'b0; fb_in = 1'b0; wait_n(4);

    // short pulse of two clocks keeps lock
    ref_in = 1'b1;
    wait_n(2);
    fb_in = 1'b1;
    wait_n(5);
    chk_state("R2 short pulse end", 1'b0, 1'b0);
    chk("R9 short pulse keeps lock", locked, 1'b1);
    ref_in = 1'b0; fb_in = 1'b0; wait_n(4);

    // long pulse clears lock
    ref_in = 1'b1;
    wait_n(10);
    chk("R7 still up", pump_up, 1'b1);
    chk("R10 long pulse drops lock", locked, 1'b0);
    fb_in = 1'b1;
    wait_n(5);
    chk_state("R2 long pulse end", 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule